// File: doc/BRIEF.md
# SPI FIFO Event and Interrupt Unit

This block sits between a host register port and the serial engine of an SPI controller. It owns a transmit byte FIFO and a receive byte FIFO. The host writes 32-bit words into the transmit FIFO and reads the receive FIFO either a whole word or a single byte at a time. The serial engine pops transmit bytes and pushes receive bytes one at a time.

Around the FIFOs the block keeps an event register, a mask register and a mode register. The event register shows live byte counts for both FIFOs. It also holds three event flags: one for receive data above a threshold, one for transmit space above a threshold, and a sticky flag for a dropped transmit write. Flags are cleared by writing ones to them. The interrupt line is raised when any set flag is also enabled in the mask.

The host port is one operation per cycle. `bus_sel` picks the register: 0 mode, 1 event, 2 mask, 3 transmit data, 4 receive data. Read data is combinational from the current state. FIFO side effects take place at the clock edge that ends the access.

Top module: `spi_fifo_evt`

## Requirements
- R1: After reset the mode register reads 0x00000403 (transmit threshold 4 in bits 13:8, receive threshold 3 in bits 5:0), the mask reads 0, both counts are 0 and `irq` is low.
- R2: A word write to select 3 queues four bytes with bits 31:24 first. The transmit count rises by 4, and the engine sees the bytes in the order 31:24, 23:16, 15:8, 7:0 on `eng_tx_data` while `eng_tx_valid` is high.
- R3: A word write when fewer than 4 bytes are free is dropped. It leaves the transmit count and contents unchanged and sets the sticky overflow flag, event bit 10.
- R4: A word read of select 4 returns the oldest byte in bits 31:24 and following bytes below it. When fewer than 4 bytes are held, it returns only those, zero-fills the lower lanes, and pops only those bytes.
- R5: A byte read (select 4 with `bus_byte` high) returns the oldest byte in bits 7:0 and pops exactly one byte. On an empty FIFO it returns 0 and pops nothing.
- R6: Event bit 9 (receive-not-empty) is set on the clock edge after the receive count exceeds the receive threshold.
- R7: Event bit 8 (transmit-not-full) is set on the clock edge after free transmit space (depth minus count) exceeds the transmit threshold.
- R8: Writing the event register clears each of bits 10:8 that is written as 1 and leaves the others. Bits 9 and 8 are set again on the next edge while their condition still holds. A cleared overflow flag stays clear until another dropped write.
- R9: `irq` is high exactly when some event bit among 10:8 is set together with the same bit of the mask register. Mask bits are written at bits 10:8 of select 2.
- R10: The event register shows the live receive byte count in bits 29:24 and the transmit byte count in bits 21:16.
- R11: An engine push into a full receive FIFO is dropped. An engine pop from an empty transmit FIFO is ignored, and both counts stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops on receive data reads) |
| bus_sel | input | 3 | Register select |
| bus_wdata | input | 32 | Write data |
| bus_byte | input | 1 | Receive read is a single byte |
| bus_rdata | output | 32 | Read data for the selected register |
| irq | output | 1 | Interrupt request |
| eng_tx_pop | input | 1 | Engine takes the transmit head byte |
| eng_tx_data | output | 8 | Transmit head byte |
| eng_tx_valid | output | 1 | Transmit FIFO holds at least one byte |
| eng_rx_push | input | 1 | Engine delivers a receive byte |
| eng_rx_data | input | 8 | Receive byte |

## Verification
The bench builds the block with its default depth of 32 bytes per FIFO. With that depth, eight word writes fill the transmit side and make the dropped-write path reachable. A short byte stream likewise saturates the receive side, so both count fields reach their top value of 32. The thresholds are reprogrammed at run time so that the transmit-space flag can be held low with a single queued word and then released by draining it. A partially filled receive FIFO drives the short word read and the empty byte read.

// File: rtl/spi_fifo_evt_pkg.sv
// Package: shared constants for the SPI FIFO event unit.
// Holds register selects, event bit positions and field geometry.
package spi_fifo_evt_pkg;
    localparam int WORD_BYTES = 4;
    localparam int CNT_W      = 6;
    localparam int THR_W      = 6;

    localparam logic [2:0] SEL_MODE  = 3'd0;
    localparam logic [2:0] SEL_EVENT = 3'd1;
    localparam logic [2:0] SEL_MASK  = 3'd2;
    localparam logic [2:0] SEL_TXD   = 3'd3;
    localparam logic [2:0] SEL_RXD   = 3'd4;

    // Event flag index within the 3-bit flag vector (bit 8 + index in the register)
    localparam int FLG_NF  = 0;
    localparam int FLG_NE  = 1;
    localparam int FLG_OVF = 2;
    localparam int FLG_LSB = 8;
    localparam int NFLAGS  = 3;

    localparam int RXCNT_LSB = 24;
    localparam int TXCNT_LSB = 16;
    localparam int TXTHR_LSB = 8;
    localparam int RXTHR_LSB = 0;

    localparam logic [THR_W-1:0] TXTHR_RST = THR_W'(4);
    localparam logic [THR_W-1:0] RXTHR_RST = THR_W'(3);
endpackage

// File: rtl/byte_fifo.sv
// Module: byte_fifo
// Byte-wide circular FIFO that accepts up to LANES bytes and releases up
// to LANES bytes per cycle. Lane 0 is the oldest byte on both sides.
// Assumes DEPTH is a power of two and that the caller never pushes more
// than the free space nor pops more than the occupancy.
module byte_fifo #(
    parameter int DEPTH = 32,
    parameter int LANES = 4,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1),
    localparam int NW = $clog2(LANES + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NW-1:0]        push_n,
    input  logic [LANES*8-1:0]   push_data,
    input  logic [NW-1:0]        pop_n,
    output logic [LANES*8-1:0]   peek_data,
    output logic [CW-1:0]        count
);
    logic [7:0]    mem [DEPTH];
    logic [AW-1:0] wp;
    logic [AW-1:0] rp;

    // Store accepted bytes at consecutive write slots
    always_ff @(posedge clk) begin
        for (int i = 0; i < LANES; i++) begin
            if (i < int'(push_n)) begin
                mem[wp + AW'(i)] <= push_data[i*8 +: 8];
            end
        end
    end

    // Advance pointers and occupancy
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            wp    <= wp + AW'(push_n);
            rp    <= rp + AW'(pop_n);
            count <= count + CW'(push_n) - CW'(pop_n);
        end
    end

    // Present the oldest LANES bytes
    for (genvar g = 0; g < LANES; g++) begin : g_peek
        assign peek_data[g*8 +: 8] = mem[rp + AW'(g)];
    end
endmodule

// File: rtl/rx_read_fmt.sv
// Module: rx_read_fmt
// Shapes receive FIFO head bytes into host read data and decides how
// many bytes a read removes. A word read places the oldest byte at the
// top lane and zero-fills lanes that hold no data; a byte read returns
// the oldest byte in the low lane. Pure combinational logic.
module rx_read_fmt #(
    parameter int DEPTH = 32,
    parameter int LANES = 4,
    localparam int CW = $clog2(DEPTH + 1),
    localparam int NW = $clog2(LANES + 1)
) (
    input  logic [LANES*8-1:0] peek_data,
    input  logic [CW-1:0]      count,
    input  logic               byte_mode,
    output logic [LANES*8-1:0] rd_data,
    output logic [NW-1:0]      pop_n
);
    logic [NW-1:0]      n_avail;
    logic [LANES*8-1:0] word_data;
    logic               nonempty;

    // Bytes available to a word read, capped at one word
    assign n_avail  = (count >= CW'(LANES)) ? NW'(LANES) : NW'(count);
    assign nonempty = (count != '0);

    // Oldest byte to the most significant lane, empty lanes zeroed
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign word_data[(LANES-1-g)*8 +: 8] =
            (NW'(g) < n_avail) ? peek_data[g*8 +: 8] : 8'h00;
    end

    // Select between word and byte formats
    always_comb begin
        if (byte_mode) begin
            rd_data = '0;
            if (nonempty) rd_data[7:0] = peek_data[7:0];
            pop_n   = nonempty ? NW'(1) : '0;
        end else begin
            rd_data = word_data;
            pop_n   = n_avail;
        end
    end
endmodule

// File: rtl/fifo_events.sv
// Module: fifo_events
// Holds the three event flags and their mask. Level conditions from the
// FIFO counts set flags every cycle they hold; a host write of ones
// clears flags; the overflow flag is set only by a dropped write. When a
// set and a clear meet in one cycle the set wins.
module fifo_events
    import spi_fifo_evt_pkg::*;
#(
    parameter int DEPTH = 32,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CW-1:0]     tx_cnt,
    input  logic [CW-1:0]     rx_cnt,
    input  logic [THR_W-1:0]  tx_thr,
    input  logic [THR_W-1:0]  rx_thr,
    input  logic              ovf_hit,
    input  logic              clr_we,
    input  logic [NFLAGS-1:0] clr_bits,
    input  logic              mask_we,
    input  logic [NFLAGS-1:0] mask_in,
    output logic [NFLAGS-1:0] flags,
    output logic [NFLAGS-1:0] mask_q,
    output logic              irq
);
    logic [NFLAGS-1:0] set_v;
    logic [NFLAGS-1:0] clr_v;
    logic [CW-1:0]     tx_free;

    // Threshold conditions from live counts
    always_comb begin
        tx_free        = CW'(DEPTH) - tx_cnt;
        set_v          = '0;
        set_v[FLG_NF]  = int'(tx_free) > int'(tx_thr);
        set_v[FLG_NE]  = int'(rx_cnt) > int'(rx_thr);
        set_v[FLG_OVF] = ovf_hit;
        clr_v          = clr_we ? clr_bits : '0;
    end

    // Flag register: write-one-to-clear, set has priority
    always_ff @(posedge clk) begin
        if (!rst_n) flags <= '0;
        else        flags <= (flags & ~clr_v) | set_v;
    end

    // Mask register
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= '0;
        else if (mask_we) mask_q <= mask_in;
    end

    // Interrupt from enabled flags
    assign irq = |(flags & mask_q);
endmodule

// File: rtl/spi_fifo_evt.sv
// Module: spi_fifo_evt (top)
// FIFO status, event and interrupt unit for an SPI controller. Decodes a
// single-operation host register port, feeds word writes into the
// transmit FIFO (dropping them when a word does not fit), serves word or
// byte reads from the receive FIFO, and exposes counts, flags, mask and
// thresholds. Assumes bus_wr and bus_rd are never high together.
module spi_fifo_evt
    import spi_fifo_evt_pkg::*;
#(
    parameter int DEPTH = 32,
    localparam int CW = $clog2(DEPTH + 1),
    localparam int NW = $clog2(WORD_BYTES + 1),
    localparam int DW = WORD_BYTES * 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [2:0]    bus_sel,
    input  logic [DW-1:0] bus_wdata,
    input  logic          bus_byte,
    output logic [DW-1:0] bus_rdata,
    output logic          irq,
    input  logic          eng_tx_pop,
    output logic [7:0]    eng_tx_data,
    output logic          eng_tx_valid,
    input  logic          eng_rx_push,
    input  logic [7:0]    eng_rx_data
);
    logic [CW-1:0]     tx_cnt;
    logic [CW-1:0]     rx_cnt;
    logic [DW-1:0]     tx_peek;
    logic [DW-1:0]     rx_peek;
    logic [DW-1:0]     tx_push_data;
    logic [DW-1:0]     rx_push_data;
    logic [NW-1:0]     tx_push_n;
    logic [NW-1:0]     tx_pop_n;
    logic [NW-1:0]     rx_push_n;
    logic [NW-1:0]     rx_pop_n;
    logic [NW-1:0]     fmt_pop_n;
    logic [DW-1:0]     fmt_data;
    logic [THR_W-1:0]  tx_thr;
    logic [THR_W-1:0]  rx_thr;
    logic [NFLAGS-1:0] ev_flags;
    logic [NFLAGS-1:0] mask_q;
    logic              tx_wr;
    logic              tx_fits;
    logic              rx_rd;

    // Host access decode
    assign tx_wr   = bus_wr && (bus_sel == SEL_TXD);
    assign rx_rd   = bus_rd && (bus_sel == SEL_RXD);
    assign tx_fits = tx_cnt <= CW'(DEPTH - WORD_BYTES);

    // Transmit word: most significant byte leaves first
    for (genvar g = 0; g < WORD_BYTES; g++) begin : g_txlane
        assign tx_push_data[g*8 +: 8] = bus_wdata[(WORD_BYTES-1-g)*8 +: 8];
    end
    assign tx_push_n    = (tx_wr && tx_fits) ? NW'(WORD_BYTES) : '0;
    assign tx_pop_n     = (eng_tx_pop && eng_tx_valid) ? NW'(1) : '0;
    assign eng_tx_valid = (tx_cnt != '0);
    assign eng_tx_data  = tx_peek[7:0];

    // Receive byte from engine into lane 0, dropped when full
    assign rx_push_data = {{(DW-8){1'b0}}, eng_rx_data};
    assign rx_push_n    = (eng_rx_push && (rx_cnt != CW'(DEPTH))) ? NW'(1) : '0;
    assign rx_pop_n     = rx_rd ? fmt_pop_n : '0;

    byte_fifo #(.DEPTH(DEPTH), .LANES(WORD_BYTES)) u_txq (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_n    (tx_push_n),
        .push_data (tx_push_data),
        .pop_n     (tx_pop_n),
        .peek_data (tx_peek),
        .count     (tx_cnt)
    );

    byte_fifo #(.DEPTH(DEPTH), .LANES(WORD_BYTES)) u_rxq (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_n    (rx_push_n),
        .push_data (rx_push_data),
        .pop_n     (rx_pop_n),
        .peek_data (rx_peek),
        .count     (rx_cnt)
    );

    rx_read_fmt #(.DEPTH(DEPTH), .LANES(WORD_BYTES)) u_fmt (
        .peek_data (rx_peek),
        .count     (rx_cnt),
        .byte_mode (bus_byte),
        .rd_data   (fmt_data),
        .pop_n     (fmt_pop_n)
    );

    fifo_events #(.DEPTH(DEPTH)) u_ev (
        .clk      (clk),
        .rst_n    (rst_n),
        .tx_cnt   (tx_cnt),
        .rx_cnt   (rx_cnt),
        .tx_thr   (tx_thr),
        .rx_thr   (rx_thr),
        .ovf_hit  (tx_wr && !tx_fits),
        .clr_we   (bus_wr && (bus_sel == SEL_EVENT)),
        .clr_bits (bus_wdata[FLG_LSB +: NFLAGS]),
        .mask_we  (bus_wr && (bus_sel == SEL_MASK)),
        .mask_in  (bus_wdata[FLG_LSB +: NFLAGS]),
        .flags    (ev_flags),
        .mask_q   (mask_q),
        .irq      (irq)
    );

    // Threshold (mode) register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_thr <= TXTHR_RST;
            rx_thr <= RXTHR_RST;
        end else if (bus_wr && (bus_sel == SEL_MODE)) begin
            tx_thr <= bus_wdata[TXTHR_LSB +: THR_W];
            rx_thr <= bus_wdata[RXTHR_LSB +: THR_W];
        end
    end

    // Host read multiplexer
    always_comb begin
        bus_rdata = '0;
        case (bus_sel)
            SEL_MODE: begin
                bus_rdata[TXTHR_LSB +: THR_W] = tx_thr;
                bus_rdata[RXTHR_LSB +: THR_W] = rx_thr;
            end
            SEL_EVENT: begin
                bus_rdata[RXCNT_LSB +: CNT_W]  = CNT_W'(rx_cnt);
                bus_rdata[TXCNT_LSB +: CNT_W]  = CNT_W'(tx_cnt);
                bus_rdata[FLG_LSB +: NFLAGS]   = ev_flags;
            end
            SEL_MASK: bus_rdata[FLG_LSB +: NFLAGS] = mask_q;
            SEL_RXD:  bus_rdata = fmt_data;
            default:  bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/spi_fifo_evt_chk.sv
// Module: spi_fifo_evt_chk
// Property checker for spi_fifo_evt, attached by bind. Observes host
// strobes, FIFO counts, flags and mask; drives nothing.
module spi_fifo_evt_chk #(
    parameter int DEPTH = 32,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_wr,
    input logic          bus_rd,
    input logic [2:0]    bus_sel,
    input logic [31:0]   bus_wdata,
    input logic          bus_byte,
    input logic          irq,
    input logic          eng_tx_pop,
    input logic          eng_rx_push,
    input logic [CW-1:0] tx_cnt,
    input logic [CW-1:0] rx_cnt,
    input logic [5:0]    tx_thr,
    input logic [5:0]    rx_thr,
    input logic [2:0]    flags,
    input logic [2:0]    mask_q
);
    // R6: receive count above threshold sets bit 9 next edge
    a_r6_ne_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(rx_cnt) > int'(rx_thr)) |=> flags[1]);

    // R7: free transmit space above threshold sets bit 8 next edge
    a_r7_nf_sets: assert property (@(posedge clk) disable iff (!rst_n)
        ((DEPTH - int'(tx_cnt)) > int'(tx_thr)) |=> flags[0]);

    // R3: a word write that does not fit raises overflow
    a_r3_ovf_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_sel == 3'd3 && int'(tx_cnt) > DEPTH - 4) |=> flags[2]);

    // R3: a dropped word leaves the transmit count alone
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_sel == 3'd3 && int'(tx_cnt) > DEPTH - 4 && !eng_tx_pop)
        |=> $stable(tx_cnt));

    // R5: a byte read of a non-empty FIFO removes one byte
    a_r5_byte_pop: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_sel == 3'd4 && bus_byte && rx_cnt != '0 && !eng_rx_push)
        |=> (rx_cnt == $past(rx_cnt) - CW'(1)));

    // R8: clearing overflow (no write in that cycle can set it)
    a_r8_ovf_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_sel == 3'd1 && bus_wdata[10]) |=> !flags[2]);

    // R9: no interrupt without some enabled mask bit
    a_r9_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (mask_q != 3'b000));

    // R10: counts never exceed the FIFO depth
    a_r10_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(tx_cnt) <= DEPTH) && (int'(rx_cnt) <= DEPTH));
endmodule

bind spi_fifo_evt spi_fifo_evt_chk #(.DEPTH(DEPTH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_wr      (bus_wr),
    .bus_rd      (bus_rd),
    .bus_sel     (bus_sel),
    .bus_wdata   (bus_wdata),
    .bus_byte    (bus_byte),
    .irq         (irq),
    .eng_tx_pop  (eng_tx_pop),
    .eng_rx_push (eng_rx_push),
    .tx_cnt      (tx_cnt),
    .rx_cnt      (rx_cnt),
    .tx_thr      (tx_thr),
    .rx_thr      (rx_thr),
    .flags       (ev_flags),
    .mask_q      (mask_q)
);

// File: tb/sim_spi_fifo_evt.sv
// Bench for spi_fifo_evt: scoreboard queues hold the bytes expected on
// the engine transmit side and on host receive reads.
module sim_spi_fifo_evt;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [2:0]  bus_sel = 3'd0;
    logic [31:0] bus_wdata = 32'h0;
    logic        bus_byte = 1'b0;
    logic [31:0] bus_rdata;
    logic        irq;
    logic        eng_tx_pop = 1'b0;
    logic [7:0]  eng_tx_data;
    logic        eng_tx_valid;
    logic        eng_rx_push = 1'b0;
    logic [7:0]  eng_rx_data = 8'h0;

    int checks = 0;
    int errors = 0;
    int tx_model = 0;
    int rx_model = 0;
    bit finished = 1'b0;
    logic [7:0] txq[$];
    logic [7:0] rxq[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_fifo_evt #(.DEPTH(DEPTH)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_sel(bus_sel), .bus_wdata(bus_wdata), .bus_byte(bus_byte),
        .bus_rdata(bus_rdata), .irq(irq), .eng_tx_pop(eng_tx_pop),
        .eng_tx_data(eng_tx_data), .eng_tx_valid(eng_tx_valid),
        .eng_rx_push(eng_rx_push), .eng_rx_data(eng_rx_data)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic reg_write(input logic [2:0] sel, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_sel = sel; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [2:0] sel, input bit byte_rd, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_sel = sel; bus_byte = byte_rd;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0; bus_byte = 1'b0;
    endtask

    // Driver: word into transmit FIFO, expected bytes into the scoreboard
    task automatic tx_word(input logic [31:0] w);
        reg_write(3'd3, w);
        if (tx_model <= DEPTH - 4) begin
            for (int k = 0; k < 4; k++) txq.push_back(w[31-8*k -: 8]);
            tx_model += 4;
        end
    endtask

    // Monitor: take n bytes from the engine side and compare in order
    task automatic tx_take(input int n, input string tag);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            chk({tag, " valid"}, {31'b0, eng_tx_valid}, 32'd1);
            if (txq.size() != 0) chk({tag, " byte"}, {24'b0, eng_tx_data}, {24'b0, txq.pop_front()});
            eng_tx_pop = 1'b1;
        end
        @(negedge clk);
        eng_tx_pop = 1'b0;
        tx_model -= n;
    endtask

    task automatic rx_push(input logic [7:0] b);
        @(negedge clk);
        eng_rx_push = 1'b1; eng_rx_data = b;
        @(negedge clk);
        eng_rx_push = 1'b0;
        if (rx_model < DEPTH) begin
            rxq.push_back(b);
            rx_model++;
        end
    endtask

    // Monitor: host word read against the receive scoreboard
    task automatic rx_word_check(input string tag);
        logic [31:0] d;
        logic [31:0] e;
        int n;
        n = (rxq.size() < 4) ? rxq.size() : 4;
        e = 32'h0;
        for (int k = 0; k < n; k++) e[31-8*k -: 8] = rxq.pop_front();
        rx_model -= n;
        reg_read(3'd4, 1'b0, d);
        chk(tag, d, e);
    endtask

    task automatic ev_check(input string tag, input logic [31:0] e);
        logic [31:0] d;
        idle(2);
        reg_read(3'd1, 1'b0, d);
        chk(tag, d, e);
    endtask

    initial begin
        repeat (20000) @(negedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=0x%08h expected=0x%08h", 32'd0, 32'd1);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        chk("R1 irq", {31'b0, irq}, 32'd0);
        reg_read(3'd0, 1'b0, d);  chk("R1 mode", d, 32'h0000_0403);
        reg_read(3'd2, 1'b0, d);  chk("R1 mask", d, 32'h0);
        ev_check("R1 event counts zero, space flag", 32'h0000_0100);

        // R2 / R10: one word, count and byte order
        tx_word(32'hA1B2_C3D4);
        ev_check("R10 tx count 4", 32'h0004_0100);
        tx_take(4, "R2");
        // R11: pop on empty transmit FIFO is ignored
        @(negedge clk); eng_tx_pop = 1'b1;
        @(negedge clk); eng_tx_pop = 1'b0;
        chk("R11 tx valid low", {31'b0, eng_tx_valid}, 32'd0);
        ev_check("R11 tx count stays 0", 32'h0000_0100);

        // R7: transmit threshold 29 keeps bit 8 low with 4 bytes queued
        reg_write(3'd0, 32'h0000_1D03);
        tx_word(32'h0102_0304);
        reg_write(3'd1, 32'h0000_0100);
        ev_check("R7 space flag held low", 32'h0004_0000);
        tx_take(4, "R7 drain");
        ev_check("R7 space flag sets", 32'h0000_0100);
        reg_write(3'd0, 32'h0000_0403);

        // R3: fill then overflow
        for (int i = 0; i < 8; i++) tx_word({8'(4*i), 8'(4*i+1), 8'(4*i+2), 8'(4*i+3)});
        reg_write(3'd1, 32'h0000_0100);
        tx_word(32'hDEAD_BEEF);
        ev_check("R3 overflow flag, count 32", 32'h0020_0400);
        // R8: overflow cleared stays clear
        reg_write(3'd1, 32'h0000_0400);
        ev_check("R8 overflow cleared", 32'h0020_0000);
        tx_take(32, "R3 contents");
        chk("R3 no dropped bytes", {31'b0, eng_tx_valid}, 32'd0);

        // R6: receive flag above threshold 3
        rx_push(8'h11); rx_push(8'h22); rx_push(8'h33);
        ev_check("R6 at threshold no flag", 32'h0300_0100);
        rx_push(8'h44);
        ev_check("R6 above threshold flag", 32'h0400_0300);

        // R9: interrupt masking
        reg_write(3'd2, 32'h0000_0200);
        chk("R9 irq enabled", {31'b0, irq}, 32'd1);
        reg_write(3'd2, 32'h0000_0400);
        chk("R9 irq masked other bit", {31'b0, irq}, 32'd0);
        reg_write(3'd2, 32'h0);
        chk("R9 irq mask zero", {31'b0, irq}, 32'd0);

        // R4: full and short word reads
        rx_word_check("R4 full word");
        rx_push(8'h55); rx_push(8'h66);
        rx_word_check("R4 short word");
        ev_check("R4 short read pops two", 32'h0000_0300);

        // R5: byte reads
        rx_push(8'h77); rx_push(8'h88);
        reg_read(3'd4, 1'b1, d); chk("R5 first byte", d, 32'h77);
        ev_check("R5 one byte left", 32'h0100_0300);
        reg_read(3'd4, 1'b1, d); chk("R5 second byte", d, 32'h88);
        reg_read(3'd4, 1'b1, d); chk("R5 empty byte", d, 32'h0);
        void'(rxq.pop_front()); void'(rxq.pop_front()); rx_model = 0;

        // R8: condition flag reasserts after clear
        for (int i = 0; i < 5; i++) rx_push(8'hA0 + 8'(i));
        reg_write(3'd1, 32'h0000_0200);
        ev_check("R8 receive flag reasserts", 32'h0500_0300);

        // R11: receive full drops extra bytes
        for (int i = 0; i < 30; i++) rx_push(8'hB0 + 8'(i));
        ev_check("R11 rx count 32", 32'h2000_0300);
        for (int i = 0; i < 8; i++) rx_word_check("R11 rx contents");
        rx_word_check("R4 empty word");

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule